// File: doc/BRIEF.md
# Thermal Escalation Controller

This block protects a multi-core package from overheating. It takes the hottest of several core temperature codes and compares it with a programmable limit. When the package runs hot, it lowers the voltage/frequency operating point shared by all cores, one level per evaluation window. It only moves to forced clock modulation on every core when the package is already at the slowest operating point and is still hot. Only core temperatures are considered.

There is one voltage regulator for the whole package, so the block drives a single operating-point index. Each index change is announced with a one-cycle request to the regulator. The block then waits for the regulator's acknowledge before it evaluates again. Cooling is handled in the reverse order. The package has to stay below the limit minus a hysteresis margin for a whole window. Modulation is dropped first, and the operating point is raised only in later windows.

Top module: `thermal_escalation_ctrl`

## Requirements
- R1: While reset is asserted and just after its release, the operating-point index is 0, the regulator request is low and no core receives a modulation request.
- R2: The package counts as hot in a cycle when at least one core's code is strictly greater than the threshold. A code equal to the threshold is not hot. Which core is hot makes no difference.
- R3: An evaluation window lasts `interval` cycles, and an interval of 0 behaves as 1. Decisions are taken only in the last cycle of a window. The index moves by exactly one per decision, with 0 the fastest point and 7 the slowest.
- R4: Each index change is accompanied by a regulator request that is high for exactly the one cycle in which the new index first appears. After that, no decision is taken until the acknowledge has been seen. A fresh window starts in the cycle after the acknowledge.
- R5: An acknowledge that arrives while no request is outstanding has no effect.
- R6: If a window was hot and the index is already 7, modulation is requested on every core and no regulator request is issued. Modulation is never requested at any index other than 7.
- R7: A window counts as cool only if, in every one of its cycles, the hottest code was strictly below threshold minus hysteresis. That bound is 0 if the hysteresis exceeds the threshold, and then no window is ever cool. A single warm cycle spoils the whole window.
- R8: When a cool window ends with modulation on, only modulation is released. The index is lowered only by later cool windows, and never below 0.
- R9: A window that contains at least one hot cycle counts as hot, and a hot window takes precedence over cooling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| core_temp_i | input | NUM_CORES*TEMP_W | Temperature codes, core k in bits [k*TEMP_W +: TEMP_W] |
| thresh_i | input | TEMP_W | Hot threshold |
| hyst_i | input | TEMP_W | Hysteresis margin below the threshold |
| interval_i | input | INTV_W | Evaluation window length in cycles |
| vr_ack_i | input | 1 | Regulator acknowledge |
| vf_idx_o | output | IDX_W | Current operating-point index, 0 is fastest |
| vr_req_o | output | 1 | One-cycle regulator request |
| clkmod_req_o | output | NUM_CORES | Clock modulation request per core |

## Verification
Temperatures sampled at the clock edge that ends a window take effect on the next edge. The new index, the regulator request and the modulation request all appear together one cycle after the last cycle of the window. An acknowledge takes effect at the edge where it is sampled, and the next window starts counting at the following edge. The bench drives inputs and compares outputs at the falling edge. It keeps an arithmetic model of window position, accumulated hot and cool flags and the pending acknowledge, so every output is checked in the exact cycle it is due. This is done over swept intervals (including 0), thresholds, hysteresis values larger than the threshold, acknowledge delays and stray acknowledges.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } te_state_e;
endpackage

// File: rtl/te_max_tree.sv
module te_max_tree #(
  parameter int NUM_CORES = 4,
  parameter int TEMP_W    = 8
) (
  input  logic [NUM_CORES*TEMP_W-1:0] temps_i,
  output logic [TEMP_W-1:0]           max_o
);
  logic [TEMP_W-1:0] run_max [NUM_CORES];

  assign run_max[0] = temps_i[TEMP_W-1:0];

  for (genvar k = 1; k < NUM_CORES; k++) begin : g_chain
    logic [TEMP_W-1:0] cur;
    assign cur        = temps_i[k*TEMP_W +: TEMP_W];
    assign run_max[k] = (cur > run_max[k-1]) ? cur : run_max[k-1];
  end

  assign max_o = run_max[NUM_CORES-1];
endmodule

// File: rtl/te_window.sv
module te_window #(
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [INTV_W-1:0] interval_i,
  input  logic              hot_i,
  input  logic              cool_i,
  output logic              eval_o,
  output logic              win_hot_o,
  output logic              win_cool_o
);
  logic [INTV_W-1:0] cnt_q, cnt_d, last_cnt;
  logic              hot_q, hot_d, cool_q, cool_d;

  assign last_cnt   = (interval_i == '0) ? '0 : interval_i - INTV_W'(1);
  assign eval_o     = !hold_i && (cnt_q >= last_cnt);
  assign win_hot_o  = hot_q | hot_i;
  assign win_cool_o = cool_q & cool_i;

  always_comb begin
    if (hold_i || eval_o) begin
      cnt_d  = '0;
      hot_d  = 1'b0;
      cool_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + INTV_W'(1);
      hot_d  = win_hot_o;
      cool_d = win_cool_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hot_q  <= 1'b0;
      cool_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      hot_q  <= hot_d;
      cool_q <= cool_d;
    end
  end
endmodule

// File: rtl/te_step_ctrl.sv
module te_step_ctrl
  import te_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic             win_hot_i,
  input  logic             win_cool_i,
  input  logic             vr_ack_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vr_req_o,
  output logic             mod_o,
  output logic             waiting_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  te_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             mod_q, mod_d, req_q, req_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    mod_d   = mod_q;
    req_d   = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (vr_ack_i) state_d = ST_RUN;
      end
      default: begin
        if (eval_i) begin
          if (win_hot_i) begin
            if (idx_q != IDX_MAX) begin
              idx_d   = idx_q + IDX_W'(1);
              req_d   = 1'b1;
              state_d = ST_WAIT;
            end else begin
              mod_d = 1'b1;
            end
          end else if (win_cool_i) begin
            if (mod_q) begin
              mod_d = 1'b0;
            end else if (idx_q != '0) begin
              idx_d   = idx_q - IDX_W'(1);
              req_d   = 1'b1;
              state_d = ST_WAIT;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      mod_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      mod_q   <= mod_d;
      req_q   <= req_d;
    end
  end

  assign idx_o     = idx_q;
  assign vr_req_o  = req_q;
  assign mod_o     = mod_q;
  assign waiting_o = (state_q == ST_WAIT);
endmodule

// File: rtl/thermal_escalation_ctrl.sv
module thermal_escalation_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int TEMP_W    = 8,
  parameter int IDX_W     = 3,
  parameter int INTV_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES*TEMP_W-1:0] core_temp_i,
  input  logic [TEMP_W-1:0]           thresh_i,
  input  logic [TEMP_W-1:0]           hyst_i,
  input  logic [INTV_W-1:0]           interval_i,
  input  logic                        vr_ack_i,
  output logic [IDX_W-1:0]            vf_idx_o,
  output logic                        vr_req_o,
  output logic [NUM_CORES-1:0]        clkmod_req_o
);
  logic [TEMP_W-1:0] max_temp, cool_bound;
  logic              is_hot, is_cool;
  logic              eval, win_hot, win_cool, waiting, mod_on;

  te_max_tree #(.NUM_CORES(NUM_CORES), .TEMP_W(TEMP_W)) u_max (
    .temps_i (core_temp_i),
    .max_o   (max_temp)
  );

  assign cool_bound = (hyst_i > thresh_i) ? '0 : thresh_i - hyst_i;
  assign is_hot     = max_temp > thresh_i;
  assign is_cool    = max_temp < cool_bound;

  te_window #(.INTV_W(INTV_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (waiting),
    .interval_i (interval_i),
    .hot_i      (is_hot),
    .cool_i     (is_cool),
    .eval_o     (eval),
    .win_hot_o  (win_hot),
    .win_cool_o (win_cool)
  );

  te_step_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (eval),
    .win_hot_i  (win_hot),
    .win_cool_i (win_cool),
    .vr_ack_i   (vr_ack_i),
    .idx_o      (vf_idx_o),
    .vr_req_o   (vr_req_o),
    .mod_o      (mod_on),
    .waiting_o  (waiting)
  );

  assign clkmod_req_o = {NUM_CORES{mod_on}};
endmodule

// File: rtl/te_checker.sv
module te_checker #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IDX_W-1:0]     vf_idx_o,
  input logic                 vr_req_o,
  input logic                 vr_ack_i,
  input logic [NUM_CORES-1:0] clkmod_req_o,
  input logic                 waiting
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vr_req_o |=> !vr_req_o); // R4

  AST_IDX_MOVES_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vf_idx_o) |-> vr_req_o); // R4

  AST_IDX_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    vr_req_o |-> ((vf_idx_o == $past(vf_idx_o) + IDX_W'(1)) ||
                  (vf_idx_o == $past(vf_idx_o) - IDX_W'(1)))); // R3

  AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !vr_ack_i) |=> !vr_req_o); // R4

  AST_MOD_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (clkmod_req_o == '0) || (clkmod_req_o == '1)); // R6

  AST_MOD_ONLY_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    clkmod_req_o[0] |-> (vf_idx_o == IDX_MAX)); // R6

  AST_RAISE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_req_o && (vf_idx_o < $past(vf_idx_o))) |-> !clkmod_req_o[0]); // R8
endmodule

bind thermal_escalation_ctrl te_checker #(
  .NUM_CORES (NUM_CORES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vf_idx_o     (vf_idx_o),
  .vr_req_o     (vr_req_o),
  .vr_ack_i     (vr_ack_i),
  .clkmod_req_o (clkmod_req_o),
  .waiting      (waiting)
);

// File: tb/thermal_escalation_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_escalation_ctrl_tb;
  localparam int NC = 4;
  localparam int TW = 8;
  localparam int IW = 3;
  localparam int VW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NC*TW-1:0] core_temp;
  logic [TW-1:0]   thresh, hyst;
  logic [VW-1:0]   interval;
  logic            vr_ack;
  logic [IW-1:0]   vf_idx;
  logic            vr_req;
  logic [NC-1:0]   clkmod;

  thermal_escalation_ctrl #(.NUM_CORES(NC), .TEMP_W(TW), .IDX_W(IW), .INTV_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_temp_i(core_temp), .thresh_i(thresh),
    .hyst_i(hyst), .interval_i(interval), .vr_ack_i(vr_ack),
    .vf_idx_o(vf_idx), .vr_req_o(vr_req), .clkmod_req_o(clkmod)
  );

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int tmp [NC];
  int thr_v, hys_v, intv_v, ack_dly, ack_cnt;
  bit spur_all, spur_rand;
  int e_idx, e_win;
  bit e_mod, e_req, e_wait, e_hacc, e_cacc;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    e_idx = 0; e_mod = 0; e_req = 0; e_wait = 0; e_win = 0; e_hacc = 0; e_cacc = 1;
  endtask

  // drive current settings and advance the model to the next rising edge
  task automatic apply();
    int mx, lo, last;
    bit hot, cool, h, c, ack;
    for (int k = 0; k < NC; k++) core_temp[k*TW +: TW] = TW'(tmp[k]);
    thresh = TW'(thr_v); hyst = TW'(hys_v); interval = VW'(intv_v);
    if (e_wait) begin
      ack = (ack_cnt == 0);
      if (ack_cnt > 0) ack_cnt--;
    end else begin
      ack = spur_all || (spur_rand && ($urandom_range(3) == 0));
    end
    vr_ack = ack;
    mx = 0;
    for (int k = 0; k < NC; k++) if (tmp[k] > mx) mx = tmp[k];
    lo   = (hys_v > thr_v) ? 0 : thr_v - hys_v;
    hot  = mx > thr_v;
    cool = mx < lo;
    e_req = 0;
    if (e_wait) begin
      if (ack) e_wait = 0;
      e_win = 0; e_hacc = 0; e_cacc = 1;
    end else begin
      last = (intv_v == 0) ? 0 : intv_v - 1;
      h = e_hacc | hot;
      c = e_cacc & cool;
      if (e_win >= last) begin
        e_win = 0; e_hacc = 0; e_cacc = 1;
        if (h) begin
          if (e_idx < 7) begin e_idx++; e_req = 1; e_wait = 1; ack_cnt = ack_dly; end
          else e_mod = 1;
        end else if (c) begin
          if (e_mod) e_mod = 0;
          else if (e_idx > 0) begin e_idx--; e_req = 1; e_wait = 1; ack_cnt = ack_dly; end
        end
      end else begin
        e_win++; e_hacc = h; e_cacc = c;
      end
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(vf_idx == IW'(e_idx), "R3 index", int'(vf_idx), e_idx);
    check(vr_req == e_req, "R4 request", int'(vr_req), int'(e_req));
    check(clkmod == (e_mod ? {NC{1'b1}} : {NC{1'b0}}), "R6 modulation", int'(clkmod), e_mod ? 15 : 0);
    apply();
  endtask

  task automatic set_all(input int v);
    for (int k = 0; k < NC; k++) tmp[k] = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(vf_idx == '0 && !vr_req && clkmod == '0, "R1 reset",
          int'({vf_idx, vr_req, clkmod}), 0);
    model_reset();
    rst_n = 1'b1;
    apply();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=200000 expected<200000 cycles");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vr_ack = 1'b0; core_temp = '0; thresh = '0; hyst = '0; interval = '0;
    thr_v = 100; hys_v = 10; intv_v = 3; ack_dly = 1; ack_cnt = 0;
    spur_all = 0; spur_rand = 0;
    set_all(20);
    model_reset();

    // R2: code equal to threshold is not hot
    do_reset();
    set_all(100);
    repeat (20) cyc();
    check(vf_idx == '0, "R2 equal-not-hot", int'(vf_idx), 0);

    // R2/R6: any single core alone drives escalation to floor then modulation
    for (int hc = 0; hc < NC; hc++) begin
      do_reset();
      set_all(20); tmp[hc] = 101;
      repeat (100) cyc();
      check(vf_idx == 3'd7, "R2 single-core escalation", int'(vf_idx), 7);
      check(clkmod == '1, "R6 floor modulation", int'(clkmod), 15);
    end

    // R5/R7: stray acknowledges and in-band temperatures change nothing
    set_all(95); spur_all = 1;
    repeat (20) cyc();
    spur_all = 0;
    check(vf_idx == 3'd7 && clkmod == '1, "R5 stray ack", int'(vf_idx), 7);

    // R8: modulation drops first, index untouched at that moment
    set_all(50);
    for (int i = 0; i < 20 && clkmod != '0; i++) cyc();
    check(clkmod == '0, "R8 release", int'(clkmod), 0);
    check(vf_idx == 3'd7, "R8 index held on release", int'(vf_idx), 7);
    repeat (150) cyc();
    check(vf_idx == '0, "R8 climb to fastest", int'(vf_idx), 0);

    // R7: one warm cycle per window blocks cooling
    intv_v = 4; set_all(120);
    for (int i = 0; i < 100 && e_idx != 2; i++) cyc();
    set_all(95);
    repeat (10) cyc();
    for (int i = 0; i < 40; i++) begin set_all((i % 4 == 3) ? 95 : 50); cyc(); end
    check(vf_idx == 3'd2, "R7 warm cycle spoils window", int'(vf_idx), 2);

    // R9: one hot cycle per window escalates
    for (int i = 0; i < 40; i++) begin set_all((i % 4 == 3) ? 101 : 95); cyc(); end
    check(vf_idx > 3'd2, "R9 hot cycle wins", int'(vf_idx), 3);

    // sweep: intervals incl. 0, hysteresis above threshold, ack delays, stray acks
    spur_rand = 1;
    for (int seg = 0; seg < 40; seg++) begin
      int base, run;
      if (seg % 8 == 0) do_reset();
      intv_v  = $urandom_range(5);
      thr_v   = 40 + $urandom_range(160);
      hys_v   = $urandom_range(60);
      ack_dly = $urandom_range(3);
      for (int n = 0; n < 500; n += run) begin
        run  = 1 + $urandom_range(12);
        base = thr_v - 30 + $urandom_range(45);
        for (int k = 0; k < NC; k++) begin
          tmp[k] = base - $urandom_range(20);
          if (tmp[k] < 0) tmp[k] = 0;
          if (tmp[k] > 255) tmp[k] = 255;
        end
        repeat (run) cyc();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule